// File: doc/BRIEF.md
# USB Frame Timer with Start-of-Frame Pulse

This block keeps the full-speed USB frame timing for a controller that can act as either host or device. In host role a down-counter measures each frame interval and produces a start-of-frame event every time it runs out. In device role the counter is restarted by a strobe from the token decoder each time an SOF token is received, and the 11-bit frame number carried by that token is captured.

Every start-of-frame event, generated or received, launches a pulse of a fixed number of clocks. Two gated copies of that pulse leave the block: one for an external pin and one for a timer trigger, each with its own enable. An end-of-periodic-frame event fires once per frame when a selectable fraction of the interval has elapsed, so that software can tell whether the periodic traffic of the frame is complete. Both events set sticky flags, cleared by writing ones, and a single interrupt line reports any flag that is not masked.

The frame number and the clocks left in the current frame are outputs, for a register file outside this block to present.

Top module: `usb_frame_timer`

## Requirements
- R1: The frame interval is `frame_reload` clocks, or `RELOAD_DEF` (48000) clocks when `frame_reload` is zero. `time_left` is 0 after reset. In host role, a cycle with `time_left` equal to 0 is a start-of-frame instant, and `time_left` is then interval-1 in the next cycle; in every other cycle it falls by one. No other start-of-frame occurs in host role.
- R2: In host role `frame_num` increases by one on every start-of-frame instant and wraps from 2047 to 0.
- R3: In device role (`host_mode` = 0), a cycle with `rx_sof_valid` high is a start-of-frame instant. In the next cycle `frame_num` equals `rx_sof_fnum` and `time_left` equals interval-1. Without the strobe, `time_left` falls by one and holds at 0. In host role `rx_sof_valid` has no effect.
- R4: Each start-of-frame instant produces a pulse that is high for exactly 12 cycles, starting in the next cycle. A new instant during a pulse restarts the 12-cycle count.
- R5: `sof_pin` follows the pulse while `sof_pin_en` is 1 and is low while it is 0.
- R6: `sof_trig` follows the pulse while `trig_en` is 1 and is low while it is 0, independently of `sof_pin_en`.
- R7: The end-of-periodic-frame event fires at most once per frame: in the first cycle in which the elapsed count, interval-1-`time_left`, is at least floor(interval × p / 100). `eopf_sel` encodes p as 00 = 80, 01 = 85, 10 = 90 and 11 = 95. No event fires before the first start-of-frame after reset.
- R8: `flags[0]` (SOF) and `flags[1]` (end of periodic frame) go high in the cycle after their event and stay high. In a cycle with `flag_clr_stb` high, each bit with a 1 in `flag_clr_bits` clears; an event in the same cycle wins over the clear.
- R9: `irq` is high exactly when some flag bit is set whose `irq_mask` bit is 0. A mask bit of 1 blocks that flag.
- R10: While reset is held, `frame_num`, `time_left`, `flags`, `irq`, `sof_pin` and `sof_trig` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode | input | 1 | 1 = host role, 0 = device role |
| frame_reload | input | 16 | Frame interval in clocks; 0 selects the default |
| eopf_sel | input | 2 | End-of-periodic-frame point (00/01/10/11 = 80/85/90/95 %) |
| sof_pin_en | input | 1 | Gates the pulse onto `sof_pin` |
| trig_en | input | 1 | Gates the pulse onto `sof_trig` |
| rx_sof_valid | input | 1 | One-cycle strobe: SOF token received |
| rx_sof_fnum | input | 11 | Frame number carried by the received token |
| irq_mask | input | 2 | Per-flag mask, 1 = masked |
| flag_clr_stb | input | 1 | Write strobe for flag clearing |
| flag_clr_bits | input | 2 | Write-one-to-clear data |
| frame_num | output | 11 | Current or last received frame number |
| time_left | output | 16 | Clocks remaining in the frame |
| flags | output | 2 | Sticky flags: bit 0 SOF, bit 1 end of periodic frame |
| irq | output | 1 | OR of the unmasked flags |
| sof_pin | output | 1 | Gated pulse for the external pin |
| sof_trig | output | 1 | Gated pulse for the timer trigger |

## Verification
On every cycle the properties hold the pulse to its exact width measured from the latest start-of-frame, keep both gated copies low while disabled, allow at most one end-of-periodic-frame event between two frame starts, and tie each event to its flag and the interrupt to the flags. They also check that the counter steps by one, and that the frame number wraps to zero in host role. The exact threshold cycle for each fraction, the default interval, the values latched from received tokens, the ignoring of strobes in host role, and the ordering of clears against events are shown only by the bench's scenarios against its cycle model.

// File: rtl/ft_pkg.sv
package ft_pkg;
  localparam int NUM_FLAGS = 2;
  localparam int FLAG_SOF  = 0;
  localparam int FLAG_EOPF = 1;

  typedef enum logic [1:0] {
    EOPF_P80 = 2'b00,
    EOPF_P85 = 2'b01,
    EOPF_P90 = 2'b10,
    EOPF_P95 = 2'b11
  } eopf_pt_e;
endpackage

// File: rtl/ft_frame_ctr.sv
module ft_frame_ctr
  import ft_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FN_W       = 11,
  parameter int RELOAD_DEF = 48000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_mode,
  input  logic [CNT_W-1:0] frame_reload,
  input  logic [1:0]       eopf_sel,
  input  logic             rx_sof_valid,
  input  logic [FN_W-1:0]  rx_sof_fnum,
  output logic [CNT_W-1:0] cnt_q,
  output logic [FN_W-1:0]  fnum_q,
  output logic             sof_evt,
  output logic             eopf_evt
);
  localparam int PW = CNT_W + 7;
  localparam logic [CNT_W-1:0] DEF_PER = RELOAD_DEF[CNT_W-1:0];
  localparam logic [FN_W-1:0]  FN_ONE  = {{(FN_W-1){1'b0}}, 1'b1};

  // interval * percentage / 100, the product formed from shifted copies
  function automatic logic [PW-1:0] eopf_threshold(input logic [CNT_W-1:0] per,
                                                   input logic [1:0] sel);
    logic [PW-1:0] x;
    logic [PW-1:0] prod;
    x    = {{7{1'b0}}, per};
    prod = (x << 6) + (x << 4);                    // 80
    case (eopf_pt_e'(sel))
      EOPF_P85: prod = prod + (x << 2) + x;        // 85
      EOPF_P90: prod = prod + (x << 3) + (x << 1); // 90
      EOPF_P95: prod = prod + (x << 3) + (x << 2) + (x << 1) + x; // 95
      default:  prod = prod;
    endcase
    return prod / PW'(100);
  endfunction

  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] top_val;
  logic [CNT_W-1:0] elapsed;
  logic [PW-1:0]    thr;
  logic             host_sof;
  logic             dev_sof;
  logic             armed_q;

  assign period   = (frame_reload == '0) ? DEF_PER : frame_reload;
  assign top_val  = period - 1'b1;
  assign elapsed  = top_val - cnt_q;
  assign thr      = eopf_threshold(period, eopf_sel);
  assign host_sof = host_mode && (cnt_q == '0);
  assign dev_sof  = !host_mode && rx_sof_valid;
  assign sof_evt  = host_sof || dev_sof;
  assign eopf_evt = armed_q && !sof_evt && ({{7{1'b0}}, elapsed} >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (sof_evt) begin
      cnt_q <= top_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fnum_q <= '0;
    end else if (host_sof) begin
      fnum_q <= fnum_q + FN_ONE;
    end else if (dev_sof) begin
      fnum_q <= rx_sof_fnum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (sof_evt) begin
      armed_q <= 1'b1;
    end else if (eopf_evt) begin
      armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ft_sof_pulse.sv
module ft_sof_pulse #(
  parameter int PULSE_W = 12,
  parameter int N_OUT   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof_evt,
  input  logic [N_OUT-1:0] out_en,
  output logic             pulse,
  output logic [N_OUT-1:0] pulse_out
);
  localparam int PCW = $clog2(PULSE_W + 1);
  localparam logic [PCW-1:0] PLOAD = PULSE_W[PCW-1:0];

  logic [PCW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (sof_evt) begin
      left_q <= PLOAD;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign pulse = (left_q != '0);

  for (genvar g = 0; g < N_OUT; g++) begin : g_gate
    assign pulse_out[g] = pulse && out_en[g];
  end
endmodule

// File: rtl/ft_irq_flags.sv
module ft_irq_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic         clr_stb,
  input  logic [N-1:0] clr_bits,
  input  logic [N-1:0] mask,
  output logic [N-1:0] flags_q,
  output logic         irq
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags_q[g] <= 1'b0;
      end else if (set_evt[g]) begin
        flags_q[g] <= 1'b1;
      end else if (clr_stb && clr_bits[g]) begin
        flags_q[g] <= 1'b0;
      end
    end
  end

  assign irq = |(flags_q & ~mask);
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import ft_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FN_W       = 11,
  parameter int PULSE_W    = 12,
  parameter int RELOAD_DEF = 48000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_mode,
  input  logic [CNT_W-1:0]     frame_reload,
  input  logic [1:0]           eopf_sel,
  input  logic                 sof_pin_en,
  input  logic                 trig_en,
  input  logic                 rx_sof_valid,
  input  logic [FN_W-1:0]      rx_sof_fnum,
  input  logic [NUM_FLAGS-1:0] irq_mask,
  input  logic                 flag_clr_stb,
  input  logic [NUM_FLAGS-1:0] flag_clr_bits,
  output logic [FN_W-1:0]      frame_num,
  output logic [CNT_W-1:0]     time_left,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irq,
  output logic                 sof_pin,
  output logic                 sof_trig
);
  logic                 sof_evt;
  logic                 eopf_evt;
  logic                 pulse;
  logic [1:0]           pulse_out;
  logic [NUM_FLAGS-1:0] set_evt;

  ft_frame_ctr #(
    .CNT_W(CNT_W), .FN_W(FN_W), .RELOAD_DEF(RELOAD_DEF)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
    .frame_reload(frame_reload), .eopf_sel(eopf_sel),
    .rx_sof_valid(rx_sof_valid), .rx_sof_fnum(rx_sof_fnum),
    .cnt_q(time_left), .fnum_q(frame_num),
    .sof_evt(sof_evt), .eopf_evt(eopf_evt)
  );

  ft_sof_pulse #(
    .PULSE_W(PULSE_W), .N_OUT(2)
  ) u_pulse (
    .clk(clk), .rst_n(rst_n), .sof_evt(sof_evt),
    .out_en({trig_en, sof_pin_en}),
    .pulse(pulse), .pulse_out(pulse_out)
  );

  assign sof_pin  = pulse_out[0];
  assign sof_trig = pulse_out[1];

  always_comb begin
    set_evt            = '0;
    set_evt[FLAG_SOF]  = sof_evt;
    set_evt[FLAG_EOPF] = eopf_evt;
  end

  ft_irq_flags #(
    .N(NUM_FLAGS)
  ) u_flags (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt),
    .clr_stb(flag_clr_stb), .clr_bits(flag_clr_bits),
    .mask(irq_mask), .flags_q(flags), .irq(irq)
  );
endmodule

// File: rtl/ft_checker.sv
module ft_checker #(
  parameter int CNT_W   = 16,
  parameter int FN_W    = 11,
  parameter int PULSE_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_mode,
  input logic             rx_sof_valid,
  input logic             sof_evt,
  input logic             eopf_evt,
  input logic             pulse,
  input logic             sof_pin,
  input logic             sof_pin_en,
  input logic             sof_trig,
  input logic             trig_en,
  input logic [FN_W-1:0]  frame_num,
  input logic [CNT_W-1:0] time_left,
  input logic [1:0]       flags,
  input logic             irq
);
  localparam int SW = $clog2(PULSE_W + 3);
  localparam logic [SW-1:0] SMAX = {SW{1'b1}};

  logic [SW-1:0] since_q;
  logic          eopf_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= SMAX;
    end else if (sof_evt) begin
      since_q <= SW'(1);
    end else if (since_q != SMAX) begin
      since_q <= since_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eopf_seen_q <= 1'b0;
    end else if (sof_evt) begin
      eopf_seen_q <= 1'b0;
    end else if (eopf_evt) begin
      eopf_seen_q <= 1'b1;
    end
  end

  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (time_left != '0 && !(rx_sof_valid && !host_mode)) |=> time_left == $past(time_left) - 1'b1); // R1
  AST_HOST_NO_EARLY_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode && time_left != '0) |-> !sof_evt); // R1
  AST_FNUM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode && sof_evt && frame_num == {FN_W{1'b1}}) |=> frame_num == '0); // R2
  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    sof_evt |=> pulse); // R4
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse) |-> since_q == SW'(PULSE_W + 1)); // R4
  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> since_q <= SW'(PULSE_W)); // R4
  AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_pin_en |-> !sof_pin); // R5
  AST_TRIG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    sof_trig |-> (trig_en && pulse)); // R6
  AST_EOPF_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    eopf_evt |-> !eopf_seen_q); // R7
  AST_EOPF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    eopf_evt |=> flags[1]); // R8
  AST_SOF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    sof_evt |=> flags[0]); // R8
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flags != 2'b00); // R9
endmodule

bind usb_frame_timer ft_checker #(
  .CNT_W(CNT_W), .FN_W(FN_W), .PULSE_W(PULSE_W)
) u_ft_checker (
  .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .rx_sof_valid(rx_sof_valid),
  .sof_evt(sof_evt), .eopf_evt(eopf_evt), .pulse(pulse),
  .sof_pin(sof_pin), .sof_pin_en(sof_pin_en), .sof_trig(sof_trig), .trig_en(trig_en),
  .frame_num(frame_num), .time_left(time_left), .flags(flags), .irq(irq)
);

// File: tb/tb_usb_frame_timer.sv
`timescale 1ns/1ps
module tb_usb_frame_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_mode = 1'b1;
  logic [15:0] frame_reload = 16'd100;
  logic [1:0]  eopf_sel = 2'b00;
  logic        sof_pin_en = 1'b0;
  logic        trig_en = 1'b0;
  logic        rx_sof_valid = 1'b0;
  logic [10:0] rx_sof_fnum = '0;
  logic [1:0]  irq_mask = 2'b00;
  logic        flag_clr_stb = 1'b0;
  logic [1:0]  flag_clr_bits = 2'b00;
  logic [10:0] frame_num;
  logic [15:0] time_left;
  logic [1:0]  flags;
  logic        irq;
  logic        sof_pin;
  logic        sof_trig;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 0;

  // reference state
  int m_cnt = 0, m_fn = 0, m_pl = 0, m_flags = 0;
  bit m_armed = 0;

  always #10 clk = ~clk;

  usb_frame_timer dut (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .frame_reload(frame_reload),
    .eopf_sel(eopf_sel), .sof_pin_en(sof_pin_en), .trig_en(trig_en),
    .rx_sof_valid(rx_sof_valid), .rx_sof_fnum(rx_sof_fnum), .irq_mask(irq_mask),
    .flag_clr_stb(flag_clr_stb), .flag_clr_bits(flag_clr_bits),
    .frame_num(frame_num), .time_left(time_left), .flags(flags), .irq(irq),
    .sof_pin(sof_pin), .sof_trig(sof_trig)
  );

  function automatic int pct_of(input logic [1:0] s);
    int p [4] = '{80, 85, 90, 95};
    return p[s];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_fn = 0; m_pl = 0; m_flags = 0; m_armed = 0;
    end else begin
      int per, thr, el, clr;
      bit sof, eop;
      per = (frame_reload == 0) ? 48000 : int'(frame_reload);
      thr = (per * pct_of(eopf_sel)) / 100;
      sof = host_mode ? (m_cnt == 0) : rx_sof_valid;
      el  = per - 1 - m_cnt;
      eop = m_armed && !sof && (el >= thr);
      if (host_mode && sof) m_fn = (m_fn + 1) % 2048;
      else if (!host_mode && sof) m_fn = int'(rx_sof_fnum);
      if (sof) m_cnt = per - 1;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_pl = sof ? 12 : (m_pl > 0 ? m_pl - 1 : 0);
      if (sof) m_armed = 1; else if (eop) m_armed = 0;
      clr = flag_clr_stb ? int'(flag_clr_bits) : 0;
      m_flags = (m_flags & ~clr & 3) | (eop ? 2 : 0) | (sof ? 1 : 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      int pul, exp_irq;
      pul = (m_pl > 0) ? 1 : 0;
      exp_irq = ((m_flags & ~int'(irq_mask) & 3) != 0) ? 1 : 0;
      chk(int'(time_left) == m_cnt, "R1 time_left", int'(time_left), m_cnt);
      if (host_mode) chk(int'(frame_num) == m_fn, "R2 frame_num", int'(frame_num), m_fn);
      else           chk(int'(frame_num) == m_fn, "R3 frame_num", int'(frame_num), m_fn);
      if (sof_pin_en) chk(int'(sof_pin) == pul, "R4 pulse", int'(sof_pin), pul);
      chk(int'(sof_pin) == (sof_pin_en ? pul : 0), "R5 sof_pin", int'(sof_pin), sof_pin_en ? pul : 0);
      chk(int'(sof_trig) == (trig_en ? pul : 0), "R6 sof_trig", int'(sof_trig), trig_en ? pul : 0);
      chk(int'(flags[1]) == ((m_flags >> 1) & 1), "R7 eopf flag", int'(flags[1]), (m_flags >> 1) & 1);
      chk(int'(flags) == m_flags, "R8 flags", int'(flags), m_flags);
      chk(int'(irq) == exp_irq, "R9 irq", int'(irq), exp_irq);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic do_reset(input logic [15:0] rl, input bit host);
    @(negedge clk); #1;
    rst_n = 1'b0; frame_reload = rl; host_mode = host;
    rx_sof_valid = 1'b0; flag_clr_stb = 1'b0;
    @(negedge clk);
    // R10: outputs idle while reset is held
    chk(time_left == 0 && frame_num == 0, "R10 counters", int'(time_left), 0);
    chk(flags == 0 && !irq, "R10 flags", int'(flags), 0);
    chk(!sof_pin && !sof_trig, "R10 pulses", int'(sof_pin), 0);
    #1; rst_n = 1'b1;
  endtask

  task automatic rx(input int fn);
    rx_sof_fnum = fn[10:0]; rx_sof_valid = 1'b1;
    step(1);
    rx_sof_valid = 1'b0;
  endtask

  task automatic clear(input logic [1:0] b);
    flag_clr_bits = b; flag_clr_stb = 1'b1;
    step(1);
    flag_clr_stb = 1'b0;
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    sof_pin_en = 1'b1;
    do_reset(16'd100, 1'b1);
    // host role, each threshold point, gating toggled
    for (int s = 0; s < 4; s++) begin
      eopf_sel = s[1:0];
      step(230);
      clear(2'b11);
    end
    trig_en = 1'b1; sof_pin_en = 1'b0; irq_mask = 2'b01;
    step(150);
    clear(2'b10);
    irq_mask = 2'b10; sof_pin_en = 1'b1;
    step(120);
    // strobes from the decoder are ignored in host role (R3)
    rx(1234); step(20); rx(7); step(90);
    // zero reload picks the 48000-clock default (R1)
    do_reset(16'd0, 1'b1);
    eopf_sel = 2'b11;
    step(48100);
    // frame number wrap (R2)
    do_reset(16'd16, 1'b1);
    eopf_sel = 2'b10;
    step(2048 * 16 + 60);
    // device role
    do_reset(16'd200, 1'b0);
    irq_mask = 2'b00; eopf_sel = 2'b01;
    step(40);                   // no SOF yet: counter holds, no event
    rx(2047); step(30);
    rx(5); step(5);
    rx(6); step(3);             // retrigger inside the pulse
    rx(100); step(250);         // run past threshold and expiry
    clear(2'b01);
    // clear and event in the same cycle: event wins (R8)
    flag_clr_bits = 2'b11; flag_clr_stb = 1'b1;
    rx(1024);
    flag_clr_stb = 1'b0;
    step(5);
    irq_mask = 2'b11; step(10);
    irq_mask = 2'b10; step(200);
    eopf_sel = 2'b00; rx(3); step(190);
    eopf_sel = 2'b11; rx(4); step(195);
    step(5);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule